// File: doc/BRIEF.md
# Scanner Front-End Color Sequencer

This block is the digital control core of a line-scan imaging front end. It holds a small register bank with a color-mode field, one offset code and one gain code per color (R, G, B), and a power-down bit. On every pixel conversion it tells the analog chain which sensor input to sample and which color's offset and gain codes to apply. It also carries the converter's data words through a fixed pipeline latency.

Everything runs on one master clock `clk_i`. A one-cycle pulse on `samp_i` marks one pixel conversion. A falling edge on `line_i` starts a new scan line. In line-rate mode the input select steps through R, G and B on successive lines. In the per-pixel modes (three-color pixel, Bayer, green stripe) the input stays on R and the offset and gain settings step from pixel to pixel in a pattern that may depend on line parity. Any write to the mode register rearms the sequence so that the next line is a well-defined first line.

Top module: `scan_color_front`

## Requirements
- R1: After reset all eight registers read as zero. `sel_o` is 0 (R input), the offset, gain and power-down outputs are 0, `data_o` is 0, line parity is even, and the mode is line-rate.
- R2: Register addresses are 1, 2, 3 for the R, G, B offsets and 4, 5, 6 for the R, G, B gains, written with `we_i`, `addr_i` and `wdata_i`. An offset register gives the sign in bit 5 (`off_neg_o`, 1 = negative) and the magnitude in bits 4:0 (`off_mag_o`). A gain register gives the x3 boost enable in bit 5 (`boost_o`) and the PGA code in bits 4:0 (`pga_o`). The outputs always show the registers of the color in use.
- R3: Line-rate mode (mode code 000 in bits 2:0 of register 0) sets `sel_o` and the color in use together. Both advance R(0) to G(1) to B(2) and back to R on each falling edge of `line_i`. A rising edge and `samp_i` leave them unchanged.
- R4: A write to address 0 makes R the color in use and sets `sel_o` to R on the next cycle. The first falling edge of `line_i` after that write keeps R and even parity. Only later falling edges advance.
- R5: In three-color pixel mode (code 001), `sel_o` stays 0. The colors run R, G, B, R, … one per `samp_i` pulse. They restart at R after every falling edge of `line_i` and after a mode write.
- R6: In Bayer mode (code 010), `sel_o` stays 0. Pixels alternate R,G on even lines and G,B on odd lines. Parity toggles on each falling edge of `line_i` except the first one after a mode write.
- R7: In green-stripe mode (code 011), `sel_o` stays 0. Pixels alternate G,R on even lines and G,B on odd lines, with parity handled as in R6.
- R8: The `data_i` word captured with `samp_i` pulse n appears on `data_o` one clock after the edge that captures pulse n+8. `data_o` changes at no other time.
- R9: `pwrdn_o` follows bit 0 of register 7. Setting it does not stop sequencing.
- R10: Mode codes 100 to 111 behave exactly as line-rate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| we_i | input | 1 | register write strobe |
| addr_i | input | 3 | register address |
| wdata_i | input | 6 | register write data |
| samp_i | input | 1 | one-cycle pixel conversion strobe |
| line_i | input | 1 | line-start, active on falling edge |
| data_i | input | 12 | converter data word |
| sel_o | output | 2 | analog input select: 0 R, 1 G, 2 B |
| off_mag_o | output | 5 | offset magnitude for current color |
| off_neg_o | output | 1 | offset sign, 1 = negative |
| pga_o | output | 5 | PGA code for current color |
| boost_o | output | 1 | x3 boost enable for current color |
| pwrdn_o | output | 1 | power-down control |
| data_o | output | 12 | data delayed by the pipeline latency |

## Verification
The bench targets the first line after a mode write. A design that advanced on that first falling edge would start with G, or on an odd Bayer line, and the scoreboard would see the wrong color on the very first pixel. It writes the mode register mid-line in line-rate mode and expects R immediately; a design that waited for a line edge would keep showing G. It drives Bayer and green-stripe through several lines, where a mishandled parity swaps the R,G and G,B pairs. It runs a code above 011 to confirm it acts as line-rate. The data scoreboard compares every word to the word from nine strobes earlier in the window; a pipeline one stage short or long fails on every pixel.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {COL_R = 2'd0, COL_G = 2'd1, COL_B = 2'd2} color_e;

  localparam logic [2:0] MODE_LINE   = 3'b000;
  localparam logic [2:0] MODE_PIX3   = 3'b001;
  localparam logic [2:0] MODE_BAYER  = 3'b010;
  localparam logic [2:0] MODE_STRIPE = 3'b011;

  function automatic logic is_line_mode(input logic [2:0] mode);
    return mode[2] | (mode == MODE_LINE);
  endfunction

  function automatic color_e next_color(input color_e c);
    case (c)
      COL_R:   return COL_G;
      COL_G:   return COL_B;
      default: return COL_R;
    endcase
  endfunction

  function automatic color_e pix_color(input logic [2:0] mode, input logic odd,
                                       input logic [1:0] pix, input color_e lcol);
    case (mode)
      MODE_PIX3:   return (pix == 2'd0) ? COL_R : (pix == 2'd1) ? COL_G : COL_B;
      MODE_BAYER:  return odd ? (pix[0] ? COL_B : COL_G) : (pix[0] ? COL_G : COL_R);
      MODE_STRIPE: return odd ? (pix[0] ? COL_B : COL_G) : (pix[0] ? COL_R : COL_G);
      default:     return lcol;
    endcase
  endfunction
endpackage

// File: rtl/scan_regs.sv
module scan_regs #(
  parameter int AW   = 3,
  parameter int RW   = 6,
  localparam int NREG = 1 << AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [RW-1:0]            wdata_i,
  output logic [NREG-1:0][RW-1:0]  regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_o[i] <= '0;
      else if (we_i && addr_i == AW'(i))           regs_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/scan_color_seq.sv
module scan_color_seq
  import scan_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       mode_wr_i,
  input  logic       fall_i,
  input  logic       samp_i,
  output color_e     color_o,
  output color_e     sel_o,
  output logic       lr_o,
  output logic       fresh_o
);
  color_e     lcol_q;
  logic       odd_q;
  logic [1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_o <= 1'b1;
      lcol_q  <= COL_R;
      odd_q   <= 1'b0;
      pix_q   <= '0;
    end else if (mode_wr_i) begin
      fresh_o <= 1'b1;
      lcol_q  <= COL_R;
      odd_q   <= 1'b0;
      pix_q   <= '0;
    end else if (fall_i) begin
      pix_q <= '0;
      if (fresh_o) begin
        fresh_o <= 1'b0;  // first line after a mode write keeps R / even
      end else begin
        lcol_q <= next_color(lcol_q);
        odd_q  <= ~odd_q;
      end
    end else if (samp_i) begin
      case (mode_i)
        MODE_PIX3:               pix_q <= (pix_q == 2'd2) ? 2'd0 : pix_q + 2'd1;
        MODE_BAYER, MODE_STRIPE: pix_q <= {1'b0, ~pix_q[0]};
        default:                 pix_q <= pix_q;
      endcase
    end
  end

  assign lr_o    = is_line_mode(mode_i);
  assign color_o = lr_o ? lcol_q : pix_color(mode_i, odd_q, pix_q, lcol_q);
  assign sel_o   = lr_o ? lcol_q : COL_R;
endmodule

// File: rtl/scan_data_delay.sv
module scan_data_delay #(
  parameter int DW  = 12,
  parameter int LAT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          samp_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  logic [LAT:0][DW-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else if (samp_i) begin
      pipe_q[0] <= data_i;
      for (int i = 1; i <= LAT; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  // extra master-clock stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= pipe_q[LAT];
  end
endmodule

// File: rtl/scan_color_front.sv
module scan_color_front
  import scan_seq_pkg::*;
#(
  parameter int DW  = 12,
  parameter int LAT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [5:0]    wdata_i,
  input  logic          samp_i,
  input  logic          line_i,
  input  logic [DW-1:0] data_i,
  output logic [1:0]    sel_o,
  output logic [4:0]    off_mag_o,
  output logic          off_neg_o,
  output logic [4:0]    pga_o,
  output logic          boost_o,
  output logic          pwrdn_o,
  output logic [DW-1:0] data_o
);
  localparam int AW    = 3;
  localparam int RW    = 6;
  localparam int NREG  = 1 << AW;
  localparam int A_OFF = 1;
  localparam int A_GN  = 4;
  localparam int A_PWR = 7;

  logic [NREG-1:0][RW-1:0] regs;
  logic   line_q, line_fall, mode_wr, lr_mode, seq_fresh;
  color_e color, sel;
  logic [RW-1:0] off_cur, gain_cur;
  logic   unused_bits;

  scan_regs #(.AW(AW), .RW(RW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .regs_o(regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign line_fall = line_q & ~line_i;
  assign mode_wr   = we_i && (addr_i == '0);

  scan_color_seq u_seq (
    .clk_i, .rst_ni,
    .mode_i   (regs[0][2:0]),
    .mode_wr_i(mode_wr),
    .fall_i   (line_fall),
    .samp_i,
    .color_o  (color),
    .sel_o    (sel),
    .lr_o     (lr_mode),
    .fresh_o  (seq_fresh)
  );

  assign off_cur   = regs[A_OFF + int'(color)];
  assign gain_cur  = regs[A_GN  + int'(color)];
  assign sel_o     = sel;
  assign off_neg_o = off_cur[5];
  assign off_mag_o = off_cur[4:0];
  assign boost_o   = gain_cur[5];
  assign pga_o     = gain_cur[4:0];
  assign pwrdn_o   = regs[A_PWR][0];
  assign unused_bits = ^{regs[0][5:3], regs[A_PWR][5:1], lr_mode, seq_fresh};

  scan_data_delay #(.DW(DW), .LAT(LAT)) u_dly (
    .clk_i, .rst_ni, .samp_i, .data_i, .data_o
  );
endmodule

// File: rtl/scan_color_front_chk.sv
module scan_color_front_chk #(
  parameter int DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [2:0]    addr_i,
  input logic [5:0]    wdata_i,
  input logic          samp_i,
  input logic [1:0]    sel_o,
  input logic          pwrdn_o,
  input logic [DW-1:0] data_o,
  input logic          lr_i,
  input logic          fall_i,
  input logic          fresh_i
);
  // R3
  line_sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_i && !fall_i && !(we_i && addr_i == 3'd0)) |=> $stable(sel_o));

  // R3
  line_sel_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_i && fall_i && !fresh_i && !(we_i && addr_i == 3'd0)) |=>
      sel_o == (($past(sel_o) == 2'd2) ? 2'd0 : $past(sel_o) + 2'd1));

  // R4
  mode_wr_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0) |=> (sel_o == 2'd0 && fresh_i));

  // R9
  pwrdn_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd7) |=> pwrdn_o == $past(wdata_i[0]));

  // R8
  data_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!samp_i && !$past(samp_i)) |=> $stable(data_o));
endmodule

bind scan_color_front scan_color_front_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .samp_i,
  .sel_o, .pwrdn_o, .data_o,
  .lr_i(lr_mode), .fall_i(line_fall), .fresh_i(seq_fresh)
);

// File: tb/tb_scan_color_front.sv
module tb_scan_color_front;
  localparam int DW  = 12;
  localparam int LAT = 8;

  logic clk = 0, rst_ni = 0;
  logic we = 0, samp = 0, line = 0;
  logic [2:0] addr = 0;
  logic [5:0] wdata = 0;
  logic [DW-1:0] din = 0;
  logic [1:0] sel;
  logic [4:0] off_mag, pga;
  logic off_neg, boost, pwrdn;
  logic [DW-1:0] dout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [5:0] off_tab [3];
  logic [5:0] gn_tab [3];
  int exp_col_q[$], exp_sel_q[$];
  string exp_req_q[$];
  logic [DW-1:0] dq[$];
  logic [DW-1:0] dval = 12'h05a;

  always #2 clk = ~clk;

  scan_color_front #(.DW(DW), .LAT(LAT)) dut (
    .clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .samp_i(samp), .line_i(line), .data_i(din),
    .sel_o(sel), .off_mag_o(off_mag), .off_neg_o(off_neg),
    .pga_o(pga), .boost_o(boost), .pwrdn_o(pwrdn), .data_o(dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [5:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic line_pulse();
    @(negedge clk); line = 1;
    @(negedge clk); line = 0;
    @(negedge clk);
  endtask

  // driver: push expected color/select, then strobe
  task automatic pix(input int col, input int s, input string req);
    @(negedge clk);
    exp_col_q.push_back(col); exp_sel_q.push_back(s); exp_req_q.push_back(req);
    samp = 1; din = dval; dval = dval + 12'd37;
    @(negedge clk); samp = 0;
    @(negedge clk);
  endtask

  // monitor: compare at each strobe, between edges
  always @(negedge clk) begin
    #1;
    if (rst_ni && samp) begin
      if (exp_col_q.size() == 0) begin
        chk(0, "scoreboard underflow", 0, 1);
      end else begin
        int c, s;
        string r;
        c = exp_col_q.pop_front(); s = exp_sel_q.pop_front(); r = exp_req_q.pop_front();
        chk(sel == 2'(s), r, sel, s);
        chk({off_neg, off_mag, boost, pga} == {off_tab[c], gn_tab[c]}, r,
            {off_neg, off_mag, boost, pga}, {off_tab[c], gn_tab[c]});
      end
      if (dq.size() == LAT + 1) begin
        logic [DW-1:0] e;
        e = dq.pop_front();
        chk(dout == e, "R8 data latency", dout, e);
      end
      dq.push_back(din);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    off_tab[0] = 6'h05; off_tab[1] = 6'h2a; off_tab[2] = 6'h1f;
    gn_tab[0]  = 6'h23; gn_tab[1]  = 6'h11; gn_tab[2]  = 6'h3f;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk({sel, off_neg, off_mag, boost, pga, pwrdn} == '0, "R1 reset outputs",
        {sel, off_neg, off_mag, boost, pga, pwrdn}, 0);
    chk(dout == '0, "R1 reset data", dout, 0);
    @(negedge clk); rst_ni = 1;

    // R2 program banks, current color R
    for (int i = 0; i < 3; i++) begin
      wr(3'(1 + i), off_tab[i]);
      wr(3'(4 + i), gn_tab[i]);
    end
    #1;
    chk({off_neg, off_mag} == off_tab[0], "R2 offset fields", {off_neg, off_mag}, off_tab[0]);
    chk({boost, pga} == gn_tab[0], "R2 gain fields", {boost, pga}, gn_tab[0]);

    // R3 / R4 line-rate
    wr(3'd0, 6'b000000);
    line_pulse();
    pix(0, 0, "R4 first line R"); pix(0, 0, "R3 line R");
    line_pulse();
    pix(1, 1, "R3 line G"); pix(1, 1, "R3 line G");
    line_pulse();
    pix(2, 2, "R3 line B");
    line_pulse();
    pix(0, 0, "R3 wrap R");
    line_pulse();
    pix(1, 1, "R3 line G again");
    // R4 mid-line mode write rearms to R
    wr(3'd0, 6'b000000);
    pix(0, 0, "R4 mid-line write R");
    line_pulse();
    pix(0, 0, "R4 first fall keeps R");
    line_pulse();
    pix(1, 1, "R4 second fall G");

    // R5 three-color pixel
    wr(3'd0, 6'b000001);
    pix(0, 0, "R5 R before line"); pix(1, 0, "R5 G");
    line_pulse();
    pix(0, 0, "R5 R"); pix(1, 0, "R5 G"); pix(2, 0, "R5 B"); pix(0, 0, "R5 wrap R");
    line_pulse();
    pix(0, 0, "R5 restart R"); pix(1, 0, "R5 G next line");
    // R9 power-down does not stop sequencing
    wr(3'd7, 6'h01);
    #1; chk(pwrdn == 1'b1, "R9 power-down set", pwrdn, 1);
    pix(2, 0, "R9 seq runs B");
    wr(3'd7, 6'h3e);
    #1; chk(pwrdn == 1'b0, "R9 power-down clear", pwrdn, 0);

    // R6 Bayer
    wr(3'd0, 6'b000010);
    line_pulse();
    pix(0, 0, "R6 even R"); pix(1, 0, "R6 even G"); pix(0, 0, "R6 even R");
    line_pulse();
    pix(1, 0, "R6 odd G"); pix(2, 0, "R6 odd B"); pix(1, 0, "R6 odd G");
    line_pulse();
    pix(0, 0, "R6 even again R"); pix(1, 0, "R6 even again G");

    // R7 green stripe
    wr(3'd0, 6'b000011);
    line_pulse();
    pix(1, 0, "R7 even G"); pix(0, 0, "R7 even R");
    line_pulse();
    pix(1, 0, "R7 odd G"); pix(2, 0, "R7 odd B");
    line_pulse();
    pix(1, 0, "R7 even again G"); pix(0, 0, "R7 even again R");

    // R10 upper codes act as line-rate
    wr(3'd0, 6'b000101);
    line_pulse();
    pix(0, 0, "R10 line R"); pix(0, 0, "R10 line R");
    line_pulse();
    pix(1, 1, "R10 line G");
    line_pulse();
    pix(2, 2, "R10 line B");

    repeat (4) @(negedge clk);
    chk(exp_col_q.size() == 0, "scoreboard drained", exp_col_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule